// File: doc/BRIEF.md
# Read-Modify-Write Shift and Bit Unit

This unit performs the single-operand modify operations of an accumulator CPU whose data width switches between a narrow mode (8 bits) and a wide mode (16 bits). It takes an operand fetched from memory or copied from the accumulator, the accumulator itself, and the current carry. It returns the modified operand together with new N, V, Z and C flag values. A four-bit write mask comes with the flags. Instruction decode and memory sequencing sit outside the block.

The supported operations are:
- increment and decrement;
- arithmetic shift left and logical shift right;
- rotate left and rotate right through carry;
- clear the accumulator's bits in the operand;
- set the accumulator's bits in the operand;
- a non-destructive bit test.

Each accepted request produces exactly one registered result one clock later. The write mask tells the flag register which flags to load, so flags that an operation does not touch keep their previous value.

Top module: `rmw_modify_unit`

## Requirements
- R1: Increment (op 0) and decrement (op 1) wrap modulo 2^width. Their mask is 4'b1010, so only N and Z are written.
- R2: Shift left (op 2) puts the operand's top bit into C and fills bit 0 with zero. Logical shift right (op 3) puts bit 0 into C and fills the top bit with zero. The mask is 4'b1011.
- R3: Rotate left (op 4) loads the incoming carry into bit 0. Rotate right (op 5) loads the incoming carry into the top bit, which is bit 7 when narrow and bit 15 when wide. The bit shifted out becomes C. The mask is 4'b1011.
- R4: For ops 0 to 5, N is the result's top bit and Z is 1 exactly when the result is zero.
- R5: Bit clear (op 6) returns operand AND NOT accumulator. Bit set (op 7) returns operand OR accumulator. For both, Z is 1 when the original operand AND accumulator is zero, and the mask is 4'b0010.
- R6: Bit test (op 8) returns the operand unchanged. N is the operand's top bit, V is the bit below it (bit 6 or bit 14), and Z is 1 when operand AND accumulator is zero. The mask is 4'b1110.
- R7: When wide is 0, only bits 7:0 are modified and bits 15:8 of the result equal the operand's bits 15:8.
- R8: The mask bit order is {N,V,Z,C}. A flag output whose mask bit is 0 reads 0. Op codes 9 to 15 return the operand with mask 0.
- R9: out_valid rises exactly one cycle after each in_valid, and all results appear with it. After reset, out_valid, result, flags and mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code (0 to 8) |
| wide | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| operand | input | 16 | Value to modify |
| acc | input | 16 | Accumulator value |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe |
| result | output | 16 | Modified operand |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_mask | output | 4 | Flag write enables {N,V,Z,C} |

## Verification
Every result, flag and mask is due exactly one clock edge after the request that caused it. The driver applies a request on a falling edge and queues the expected item, which a reference function computes from the requirements. The monitor samples on each later falling edge, so it reads out_valid half a period after the edge that registered the result. It then pops the queue in order, which keeps back-to-back requests aligned. At the end the bench requires the queue to be empty and out_valid to be low, so a dropped result or an extra result counts as a mismatch.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   localparam logic [3:0] OP_INC = 4'd0;
   localparam logic [3:0] OP_DEC = 4'd1;
   localparam logic [3:0] OP_SHL = 4'd2;
   localparam logic [3:0] OP_SHR = 4'd3;
   localparam logic [3:0] OP_RTL = 4'd4;
   localparam logic [3:0] OP_RTR = 4'd5;
   localparam logic [3:0] OP_CLR = 4'd6;
   localparam logic [3:0] OP_SET = 4'd7;
   localparam logic [3:0] OP_TST = 4'd8;

   // mask bit order {N,V,Z,C}
   localparam logic [3:0] MSK_NZ  = 4'b1010;
   localparam logic [3:0] MSK_NZC = 4'b1011;
   localparam logic [3:0] MSK_Z   = 4'b0010;
   localparam logic [3:0] MSK_NVZ = 4'b1110;

   function automatic logic [3:0] mask_for(input logic [3:0] op);
      case (op)
         OP_INC, OP_DEC:                 mask_for = MSK_NZ;
         OP_SHL, OP_SHR, OP_RTL, OP_RTR: mask_for = MSK_NZC;
         OP_CLR, OP_SET:                 mask_for = MSK_Z;
         OP_TST:                         mask_for = MSK_NVZ;
         default:                        mask_for = 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/rmw_shifter.sv
module rmw_shifter #(
   parameter int W = 8
) (
   input  logic [W-1:0] opnd,
   input  logic         cin,
   input  logic [3:0]   op,
   output logic [W-1:0] res,
   output logic         cout
);
   import rmw_pkg::*;

   initial begin
      if (W < 2) $error("rmw_shifter: W must be at least 2");
   end

   always_comb begin
      res  = opnd;
      cout = cin;
      case (op)
         OP_INC: res = opnd + 1'b1;
         OP_DEC: res = opnd - 1'b1;
         OP_SHL: begin res = {opnd[W-2:0], 1'b0}; cout = opnd[W-1]; end
         OP_SHR: begin res = {1'b0, opnd[W-1:1]}; cout = opnd[0];   end
         OP_RTL: begin res = {opnd[W-2:0], cin};  cout = opnd[W-1]; end
         OP_RTR: begin res = {cin, opnd[W-1:1]};  cout = opnd[0];   end
         default: ;
      endcase
   end
endmodule

// File: rtl/rmw_bitops.sv
module rmw_bitops #(
   parameter int W = 8
) (
   input  logic [W-1:0] opnd,
   input  logic [W-1:0] acc,
   input  logic [3:0]   op,
   output logic [W-1:0] res,
   output logic         common_zero
);
   import rmw_pkg::*;

   assign common_zero = ((opnd & acc) == '0);

   always_comb begin
      case (op)
         OP_CLR:  res = opnd & ~acc;
         OP_SET:  res = opnd | acc;
         default: res = opnd;
      endcase
   end
endmodule

// File: rtl/rmw_lane.sv
module rmw_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] opnd,
   input  logic [W-1:0] acc,
   input  logic         cin,
   input  logic [3:0]   op,
   output logic [W-1:0] res,
   output logic [3:0]   flags   // {N,V,Z,C}, unmasked
);
   import rmw_pkg::*;

   logic [W-1:0] sh_res, bo_res;
   logic         sh_c, bo_z;
   logic         is_bitop;

   rmw_shifter #(.W(W)) u_sh (
      .opnd(opnd), .cin(cin), .op(op), .res(sh_res), .cout(sh_c)
   );

   rmw_bitops #(.W(W)) u_bo (
      .opnd(opnd), .acc(acc), .op(op), .res(bo_res), .common_zero(bo_z)
   );

   assign is_bitop = (op == OP_CLR) || (op == OP_SET) || (op == OP_TST);

   always_comb begin
      if (is_bitop) begin
         res   = bo_res;
         flags = {opnd[W-1], opnd[W-2], bo_z, sh_c};
      end else begin
         res   = sh_res;
         flags = {sh_res[W-1], 1'b0, (sh_res == '0), sh_c};
      end
   end
endmodule

// File: rtl/rmw_modify_unit.sv
module rmw_modify_unit #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic              wide,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] acc,
   input  logic              carry_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_v,
   output logic              flag_z,
   output logic              flag_c,
   output logic [3:0]        flag_mask
);
   import rmw_pkg::*;

   localparam int NLANES = 2;
   localparam int HIGH_W = DATA_W - NARROW_W;

   initial begin
      if (NARROW_W < 2)       $error("rmw_modify_unit: NARROW_W must be at least 2");
      if (DATA_W <= NARROW_W) $error("rmw_modify_unit: DATA_W must exceed NARROW_W");
   end

   logic [DATA_W-1:0] lane_res [NLANES];
   logic [3:0]        lane_flg [NLANES];

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? NARROW_W : DATA_W;
      logic [LW-1:0] l_res;
      rmw_lane #(.W(LW)) u_lane (
         .opnd (operand[LW-1:0]),
         .acc  (acc[LW-1:0]),
         .cin  (carry_in),
         .op   (op),
         .res  (l_res),
         .flags(lane_flg[g])
      );
      if (LW < DATA_W) begin : g_keep_high
         assign lane_res[g] = {operand[DATA_W-1:LW], l_res};
      end else begin : g_full
         assign lane_res[g] = l_res;
      end
   end

   logic [3:0]        d_mask, d_flags;
   logic [DATA_W-1:0] d_res;

   assign d_mask  = mask_for(op);
   assign d_res   = wide ? lane_res[1] : lane_res[0];
   assign d_flags = (wide ? lane_flg[1] : lane_flg[0]) & d_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flag_mask <= '0;
         {flag_n, flag_v, flag_z, flag_c} <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= d_res;
            flag_mask <= d_mask;
            {flag_n, flag_v, flag_z, flag_c} <= d_flags;
         end
      end
   end

   // R9: one result per request, one cycle later
   assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R1: increment/decrement never write carry
   assert_incdec_keep_c_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op == OP_INC || op == OP_DEC) |=> flag_mask == 4'b1010);
   // R7: narrow mode keeps the high part
   assert_narrow_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !wide |=> result[DATA_W-1:NARROW_W] == $past(operand[DATA_W-1:NARROW_W]));
   // R6: bit test does not alter data
   assert_test_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == OP_TST |=> result == $past(operand));
   // R8: unmasked flags read zero
   assert_unmasked_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ({flag_n, flag_v, flag_z, flag_c} & ~flag_mask) == 4'b0000);

   logic unused_hw;
   assign unused_hw = (HIGH_W == 0);
endmodule

// File: tb/rmw_modify_unit_test.sv
module rmw_modify_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic        wide = 1'b0;
   logic [15:0] operand = '0;
   logic [15:0] acc = '0;
   logic        carry_in = 1'b0;
   logic        out_valid;
   logic [15:0] result;
   logic        flag_n, flag_v, flag_z, flag_c;
   logic [3:0]  flag_mask;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct packed {
      logic [15:0] res;
      logic [3:0]  flg;   // {N,V,Z,C}
      logic [3:0]  msk;
      logic [3:0]  op;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   rmw_modify_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
      .operand(operand), .acc(acc), .carry_in(carry_in), .out_valid(out_valid),
      .result(result), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
      .flag_c(flag_c), .flag_mask(flag_mask)
   );

   function automatic string req_of(logic [3:0] o);
      case (o)
         4'd0, 4'd1:       return "R1/R4/R7";
         4'd2, 4'd3:       return "R2/R4/R7";
         4'd4, 4'd5:       return "R3/R4/R7";
         4'd6, 4'd7:       return "R5/R7";
         4'd8:             return "R6/R7";
         default:          return "R8";
      endcase
   endfunction

   function automatic exp_t model(logic [3:0] o, logic w16, logic [15:0] a_in,
                                  logic [15:0] ac, logic ci);
      exp_t e;
      int          w = w16 ? 16 : 8;
      logic [15:0] m = w16 ? 16'hFFFF : 16'h00FF;
      logic [15:0] a = a_in & m;
      logic [15:0] b = ac & m;
      logic [15:0] r = a;
      logic n = 0, v = 0, z = 0, c = 0;
      logic [3:0] mk = 4'b0000;
      case (o)
         4'd0: begin r = (a + 16'd1) & m; mk = 4'b1010; end
         4'd1: begin r = (a - 16'd1) & m; mk = 4'b1010; end
         4'd2: begin r = (a << 1) & m; c = a[w-1]; mk = 4'b1011; end
         4'd3: begin r = a >> 1; c = a[0]; mk = 4'b1011; end
         4'd4: begin r = ((a << 1) | {15'd0, ci}) & m; c = a[w-1]; mk = 4'b1011; end
         4'd5: begin r = (a >> 1) | ({15'd0, ci} << (w-1)); c = a[0]; mk = 4'b1011; end
         4'd6: begin r = a & ~b; z = ((a & b) == 0); mk = 4'b0010; end
         4'd7: begin r = a | b;  z = ((a & b) == 0); mk = 4'b0010; end
         4'd8: begin n = a[w-1]; v = a[w-2]; z = ((a & b) == 0); mk = 4'b1110; end
         default: ;
      endcase
      if (o <= 4'd5) begin
         n = r[w-1];
         z = (r == 0);
      end
      e.res = (a_in & ~m) | r;
      e.flg = {n, v, z, c};
      e.msk = mk;
      e.op  = o;
      return e;
   endfunction

   task automatic drive(logic [3:0] o, logic w16, logic [15:0] a, logic [15:0] b, logic ci);
      op = o; wide = w16; operand = a; acc = b; carry_in = ci; in_valid = 1'b1;
      sb.push_back(model(o, w16, a, b, ci));
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: results are due one edge after the request
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         exp_t e;
         exp_t got;
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R9: unexpected out_valid, result=%h expected none", result);
         end else begin
            e = sb.pop_front();
            got.res = result;
            got.flg = {flag_n, flag_v, flag_z, flag_c};
            got.msk = flag_mask;
            got.op  = e.op;
            if (got != e) begin
               fails++;
               $display("FAIL %s: op=%0d result=%h flags=%b mask=%b expected result=%h flags=%b mask=%b",
                        req_of(e.op), e.op, got.res, got.flg, got.msk, e.res, e.flg, e.msk);
            end
         end
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      // R9 reset state
      checks++;
      if (out_valid !== 1'b0 || result !== 16'h0 || flag_mask !== 4'h0 ||
          {flag_n, flag_v, flag_z, flag_c} !== 4'h0) begin
         fails++;
         $display("FAIL R9: reset state valid=%b result=%h mask=%b expected 0/0000/0000",
                  out_valid, result, flag_mask);
      end
      rst_n = 1'b1;
      @(negedge clk);

      drive(4'd0, 1'b0, 16'hABFF, 16'h0000, 1'b1); // R1 R7 narrow wrap to zero
      drive(4'd0, 1'b1, 16'hFFFF, 16'h0000, 1'b0); // R1 wide wrap
      drive(4'd1, 1'b1, 16'h0000, 16'h0000, 1'b0); // R1 wide underflow, N set
      drive(4'd1, 1'b0, 16'h3400, 16'h0000, 1'b1); // R1 R7 narrow underflow
      drive(4'd2, 1'b0, 16'h5581, 16'h0000, 1'b0); // R2 shift left carry out
      drive(4'd3, 1'b1, 16'h0001, 16'h0000, 1'b0); // R2 shift right to zero
      drive(4'd2, 1'b1, 16'h4000, 16'h0000, 1'b1); // R2 R4 zero fill, N
      drive(4'd4, 1'b0, 16'h0080, 16'h0000, 1'b1); // R3 rotate left with carry
      drive(4'd5, 1'b1, 16'h0002, 16'h0000, 1'b1); // R3 rotate right into bit 15
      drive(4'd5, 1'b0, 16'hFF02, 16'h0000, 1'b1); // R3 R7 rotate right into bit 7
      drive(4'd6, 1'b1, 16'hF0F0, 16'h00FF, 1'b0); // R5 clear, overlap
      drive(4'd7, 1'b0, 16'h1200, 16'h0033, 1'b0); // R5 set, no overlap
      drive(4'd8, 1'b1, 16'h4000, 16'h0001, 1'b0); // R6 V from bit 14
      drive(4'd8, 1'b0, 16'h9980, 16'h0080, 1'b1); // R6 N from bit 7
      drive(4'd12, 1'b1, 16'h1234, 16'hFFFF, 1'b1); // R8 unused code

      lf = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
         logic [15:0] a, b;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         a  = lf;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         b  = lf;
         drive(4'(i % 10), b[3], a, b ^ 16'h5A5A, b[7]);
      end

      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0 || out_valid) begin
         fails++;
         $display("FAIL R9: %0d results missing, out_valid=%b expected 0/0", sb.size(), out_valid);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R9: watchdog expired, done=0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule